// File: doc/BRIEF.md
# Read-Data CRC-8 Appender

This block sits between the register-read datapath and the serial transmitter of a single-wire slave. Each transaction opens with a start strobe that carries the instruction opcode. Data bytes then arrive as a valid/data stream, and a last flag marks the final byte. Every byte passes to the transmitter one cycle later, unchanged. For a read transaction, the block shifts each byte into an 8-bit LFSR as it passes, least significant bit first. The LFSR uses the generator x^8 + x^5 + x^4 + 1 and is cleared to zero at the start. After the final data byte, the LFSR contents go out as one extra byte, flagged as a CRC byte.

Write and other transactions pass through and get no CRC. A start strobe that arrives while a CRC byte is still waiting to go out cancels that byte and reseeds the LFSR.

The block also has a self-check mode, chosen at start time. In this mode the stream is expected to end with its own CRC byte. No CRC is appended. Instead, a one-cycle check pulse reports whether the residue over data plus CRC is zero. A parameter removes this mode entirely.

Top module: `rdcrc_appender`

## Requirements
- R1: After reset, out_valid_o, out_crc_o, chk_valid_o and chk_ok_o are all 0.
- R2: A byte presented with in_valid_i=1 in cycle n appears on out_data_o with out_valid_o=1 and out_crc_o=0 in cycle n+1, unchanged.
- R3: For a transaction whose start opcode equals binary 10, the cycle after the last data byte leaves the block carries one byte with out_valid_o=1 and out_crc_o=1. That byte is the CRC of all data bytes: the LFSR is seeded with 0, and bits are taken bit 0 first. On each bit, feedback = crc[0] XOR data bit; crc is shifted right one place and XORed with 8'h8C when feedback is 1. For the string "123456789" the CRC is 8'hA1, and for the single byte 8'h01 it is 8'h5E. Bit 0 of the CRC byte is its first transmitted bit.
- R4: For opcodes 00, 01 and 11, with or without self-check mode, no CRC byte is output and no check pulse occurs.
- R5: The LFSR is cleared at every start strobe, so a read's CRC does not depend on earlier transactions.
- R6: A start strobe in the cycle after the last byte of a read cancels the pending CRC byte: no byte or check pulse follows.
- R7: With verify_i=1 at start of a read, no CRC byte is appended. Instead, in the cycle after the last byte leaves, chk_valid_o pulses for one cycle. chk_ok_o=1 exactly when the residue over all bytes is zero, which is true for data followed by its own CRC and false for a corrupted stream.
- R8: A read with a single data byte (first byte also last) gets its CRC appended correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transaction start strobe |
| opcode_i | input | OPC_W | Instruction opcode, sampled with start_i |
| verify_i | input | 1 | Self-check mode select, sampled with start_i |
| in_valid_i | input | 1 | Input data byte valid |
| in_data_i | input | DATA_W | Input data byte |
| in_last_i | input | 1 | Marks the final data byte |
| out_valid_o | output | 1 | Byte to transmitter valid |
| out_data_o | output | DATA_W | Byte to transmitter |
| out_crc_o | output | 1 | Current output byte is the appended CRC |
| chk_valid_o | output | 1 | Self-check result pulse |
| chk_ok_o | output | 1 | Self-check residue was zero |

## Verification
The CRC path is tried with the nine-byte ASCII string "123456789" and with the single byte 01, whose known residues catch a wrong polynomial, seed, bit order or shift direction. Repeated reads of the same data separated by different data show whether the seed is cleared. The three non-read opcodes check that the CRC is gated by opcode rather than always produced. A start strobe placed exactly in the pending cycle shows whether cancellation works. In self-check mode, a stream with its correct CRC appended and the same stream with one flipped bit show whether the residue comparison really tells good data from bad.

// File: rtl/rdcrc_pkg.sv
package rdcrc_pkg;
   localparam int unsigned RDCRC_BYTE_W   = 8;
   localparam int unsigned RDCRC_OPC_W    = 2;
   localparam logic [1:0]  RDCRC_OP_READ  = 2'b10;
   localparam logic [7:0]  RDCRC_POLY_REV = 8'h8C;

   typedef struct packed {
      logic rd;
      logic ver;
   } rdcrc_mode_t;
endpackage

// File: rtl/rdcrc_lfsr_step.sv
module rdcrc_lfsr_step #(
   parameter int unsigned          CRC_W  = 8,
   parameter int unsigned          DATA_W = 8,
   parameter logic [CRC_W-1:0]     POLY   = 8'h8C
) (
   input  logic [CRC_W-1:0]  crc_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc_i;

   for (genvar g = 0; g < DATA_W; g++) begin : g_bit
      logic fb;
      assign fb           = stage[g][0] ^ data_i[g];
      assign stage[g+1]   = (stage[g] >> 1) ^ (fb ? POLY : '0);
   end

   assign crc_o = stage[DATA_W];
endmodule

// File: rtl/rdcrc_lfsr_reg.sv
module rdcrc_lfsr_reg #(
   parameter int unsigned          CRC_W  = 8,
   parameter int unsigned          DATA_W = 8,
   parameter logic [CRC_W-1:0]     POLY   = 8'h8C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              adv_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CRC_W-1:0]  crc_o
);
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] base;
   logic [CRC_W-1:0] stepped;

   assign base = clr_i ? '0 : crc_q;

   rdcrc_lfsr_step #(
      .CRC_W (CRC_W),
      .DATA_W(DATA_W),
      .POLY  (POLY)
   ) u_step (
      .crc_i (base),
      .data_i(data_i),
      .crc_o (stepped)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q <= '0;
      end else if (adv_i) begin
         crc_q <= stepped;
      end else if (clr_i) begin
         crc_q <= '0;
      end
   end

   assign crc_o = crc_q;

   // R5: a clear with no data in the same cycle leaves a zero seed
   assert_reseed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !adv_i) |=> (crc_o == '0));
endmodule

// File: rtl/rdcrc_appender.sv
module rdcrc_appender
   import rdcrc_pkg::*;
#(
   parameter int unsigned         DATA_W        = RDCRC_BYTE_W,
   parameter int unsigned         CRC_W         = RDCRC_BYTE_W,
   parameter int unsigned         OPC_W         = RDCRC_OPC_W,
   parameter logic [OPC_W-1:0]    OPC_READ      = RDCRC_OP_READ,
   parameter logic [CRC_W-1:0]    POLY          = RDCRC_POLY_REV,
   parameter bit                  SELF_CHECK_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPC_W-1:0]  opcode_i,
   input  logic              verify_i,
   input  logic              in_valid_i,
   input  logic [DATA_W-1:0] in_data_i,
   input  logic              in_last_i,
   output logic              out_valid_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_crc_o,
   output logic              chk_valid_o,
   output logic              chk_ok_o
);
   // elaboration-time parameter checks
   if (CRC_W != DATA_W) begin : g_bad_width
      $error("rdcrc_appender: CRC_W must equal DATA_W to be sent as one byte");
   end
   if (OPC_W < 1) begin : g_bad_opc
      $error("rdcrc_appender: OPC_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("rdcrc_appender: DATA_W must be at least 1");
   end

   rdcrc_mode_t      mode_q;
   rdcrc_mode_t      mode_eff;
   logic             pend_q;
   logic             flush;
   logic             take;
   logic             ver_req;
   logic [CRC_W-1:0] crc;

   // variant: self-check mode present or removed
   if (SELF_CHECK_EN) begin : g_chk
      assign ver_req = verify_i;
   end else begin : g_nochk
      logic unused_ver;
      assign unused_ver = verify_i;
      assign ver_req    = 1'b0;
   end

   assign mode_eff.rd  = start_i ? (opcode_i == OPC_READ) : mode_q.rd;
   assign mode_eff.ver = start_i ? ver_req                : mode_q.ver;

   // pending CRC goes out unless a new start cancels it
   assign flush = pend_q && !start_i;
   assign take  = in_valid_i && !flush;

   rdcrc_lfsr_reg #(
      .CRC_W (CRC_W),
      .DATA_W(DATA_W),
      .POLY  (POLY)
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_i),
      .adv_i (take && mode_eff.rd),
      .data_i(in_data_i),
      .crc_o (crc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         pend_q <= 1'b0;
      end else begin
         mode_q <= mode_eff;
         pend_q <= take && in_last_i && mode_eff.rd;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_data_o  <= '0;
         out_crc_o   <= 1'b0;
         chk_valid_o <= 1'b0;
         chk_ok_o    <= 1'b0;
      end else begin
         out_valid_o <= 1'b0;
         out_crc_o   <= 1'b0;
         chk_valid_o <= 1'b0;
         if (flush) begin
            if (mode_q.ver) begin
               chk_valid_o <= 1'b1;
               chk_ok_o    <= (crc == '0);
            end else begin
               out_valid_o <= 1'b1;
               out_data_o  <= crc;
               out_crc_o   <= 1'b1;
            end
         end else if (in_valid_i) begin
            out_valid_o <= 1'b1;
            out_data_o  <= in_data_i;
         end
      end
   end

   // R2: accepted bytes pass through one cycle later
   assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (out_valid_o && !out_crc_o && out_data_o == $past(in_data_i)));

   // R3: a pending read CRC not cancelled appears next cycle
   assert_crc_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !mode_q.ver && !start_i) |=> (out_valid_o && out_crc_o));

   // R4: CRC byte only for a read transaction outside self-check mode
   assert_crc_only_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_crc_o |-> (mode_q.rd && !mode_q.ver));

   // R6: start in the pending cycle suppresses the CRC byte and check pulse
   assert_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && start_i) |=> (!out_crc_o && !chk_valid_o));

   // R7: check pulse only in self-check mode, never alongside a CRC byte
   assert_chk_only_verify_R7: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid_o |-> (mode_q.ver && mode_q.rd && !out_crc_o));
endmodule

// File: tb/rdcrc_appender_tb.sv
module rdcrc_appender_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       start;
   logic [1:0] opcode;
   logic       verify;
   logic       in_valid;
   logic [7:0] in_data;
   logic       in_last;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_crc;
   logic       chk_valid;
   logic       chk_ok;

   int   n_tot  = 0;
   int   n_pass = 0;
   bit   done   = 1'b0;
   logic [7:0] dbuf [16];

   always #2 clk = ~clk;

   rdcrc_appender u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .opcode_i   (opcode),
      .verify_i   (verify),
      .in_valid_i (in_valid),
      .in_data_i  (in_data),
      .in_last_i  (in_last),
      .out_valid_o(out_valid),
      .out_data_o (out_data),
      .out_crc_o  (out_crc),
      .chk_valid_o(chk_valid),
      .chk_ok_o   (chk_ok)
   );

   function automatic logic [7:0] model_crc(input int n);
      logic [7:0] c = 8'h00;
      for (int i = 0; i < n; i++) begin
         for (int b = 0; b < 8; b++) begin
            logic fb;
            fb = c[0] ^ dbuf[i][b];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
         end
      end
      return c;
   endfunction

   task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_tot++;
      if (ok) n_pass++;
      else $display("FAIL %s: actual %h expected %h", rq, act, exp);
   endtask

   // drives one transaction and checks each passed-through byte (R2)
   task automatic drive_txn(input logic [1:0] opc, input logic ver, input int n);
      @(negedge clk);
      start = 1'b1; opcode = opc; verify = ver; in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1; in_data = dbuf[i]; in_last = (i == n - 1);
         @(negedge clk);
         check(out_valid && !out_crc && out_data == dbuf[i], "R2 passthru",
               {22'd0, out_valid, out_crc, out_data}, {22'd0, 2'b10, dbuf[i]});
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic expect_crc(input logic [7:0] exp, input string rq);
      @(negedge clk);
      check(out_valid && out_crc && out_data == exp, rq,
            {22'd0, out_valid, out_crc, out_data}, {22'd0, 2'b11, exp});
      @(negedge clk);
      check(!out_valid && !out_crc, {rq, " single extra byte"},
            {30'd0, out_valid, out_crc}, 32'd0);
   endtask

   task automatic t_reset();
      check(!out_valid && !out_crc && !chk_valid && !chk_ok, "R1 reset outputs",
            {28'd0, out_valid, out_crc, chk_valid, chk_ok}, 32'd0);
   endtask

   task automatic t_golden();
      string s = "123456789";
      for (int i = 0; i < 9; i++) dbuf[i] = s[i];
      drive_txn(2'b10, 1'b0, 9);
      expect_crc(8'hA1, "R3 crc of 123456789");
      check(model_crc(9) == 8'hA1, "R3 model sanity", {24'd0, model_crc(9)}, 32'hA1);
   endtask

   task automatic t_single();
      dbuf[0] = 8'h01;
      drive_txn(2'b10, 1'b0, 1);
      expect_crc(8'h5E, "R8 single byte 01 (R3 bit order)");
      dbuf[0] = 8'hC3;
      drive_txn(2'b10, 1'b0, 1);
      expect_crc(model_crc(1), "R8 single byte C3");
   endtask

   task automatic t_nonread();
      logic [1:0] ops [3] = '{2'b00, 2'b01, 2'b11};
      for (int k = 0; k < 3; k++) begin
         for (int i = 0; i < 4; i++) dbuf[i] = 8'h30 + 8'(i * 7 + k);
         drive_txn(ops[k], 1'(k == 1), 4);
         @(negedge clk);
         check(!out_valid && !out_crc && !chk_valid, "R4 no crc for non-read",
               {29'd0, out_valid, out_crc, chk_valid}, 32'd0);
      end
   endtask

   task automatic t_reseed();
      logic [7:0] a [4] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
      for (int i = 0; i < 4; i++) dbuf[i] = a[i];
      drive_txn(2'b10, 1'b0, 4);
      expect_crc(model_crc(4), "R5 first read");
      for (int i = 0; i < 4; i++) dbuf[i] = ~a[i];
      drive_txn(2'b10, 1'b0, 4);
      expect_crc(model_crc(4), "R5 other data");
      for (int i = 0; i < 4; i++) dbuf[i] = a[i];
      drive_txn(2'b10, 1'b0, 4);
      expect_crc(model_crc(4), "R5 repeat read after reseed");
   endtask

   task automatic t_abort();
      for (int i = 0; i < 3; i++) dbuf[i] = 8'h11 * 8'(i + 1);
      drive_txn(2'b10, 1'b0, 3);
      start = 1'b1; opcode = 2'b01; verify = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(!out_valid && !out_crc && !chk_valid, "R6 start cancels pending crc",
            {29'd0, out_valid, out_crc, chk_valid}, 32'd0);
      @(negedge clk);
      check(!out_valid && !out_crc, "R6 nothing late", {30'd0, out_valid, out_crc}, 32'd0);
      drive_txn(2'b10, 1'b0, 3);
      expect_crc(model_crc(3), "R6 read after abort");
   endtask

   task automatic t_verify();
      for (int i = 0; i < 5; i++) dbuf[i] = 8'h5A ^ 8'(i * 37);
      dbuf[5] = model_crc(5);
      drive_txn(2'b10, 1'b1, 6);
      @(negedge clk);
      check(!out_valid && chk_valid && chk_ok, "R7 good stream residue zero",
            {29'd0, out_valid, chk_valid, chk_ok}, 32'b011);
      @(negedge clk);
      check(!chk_valid, "R7 pulse one cycle", {31'd0, chk_valid}, 32'd0);
      dbuf[2] = dbuf[2] ^ 8'h04;
      drive_txn(2'b10, 1'b1, 6);
      @(negedge clk);
      check(!out_valid && chk_valid && !chk_ok, "R7 corrupted stream flagged",
            {29'd0, out_valid, chk_valid, chk_ok}, 32'b010);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; opcode = 2'b00; verify = 1'b0;
      in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_golden();
      t_single();
      t_nonread();
      t_reseed();
      t_abort();
      t_verify();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_tot++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_pass, n_tot);
         $finish;
      end
   end
endmodule